// File: doc/BRIEF.md
# Character Display Power-Up Initialization Sequencer

This block brings up a 4-bit character display after reset and then acts as its normal write port. Coming out of reset it first idles for a fixed settling period. It then walks a constant table of command nibbles from the first entry to the last. Each entry goes to the display as one nibble write with the register-select line low. Each write has a setup phase, an enable pulse and a long recovery phase. The table is fixed when the design is elaborated. Its length and contents are parameters, and the walk stops at the last entry without wrapping.

The table holds nibbles rather than bytes. A full command byte therefore takes two entries, high half first; the bytes 0x86, 0xC2 and 0xFF become the entries 8, 6, C, 2, F, F. A lone mode-setting nibble is simply one entry. When the recovery of the last entry has ended, `init_done` rises and stays high until the next reset.

From then on, user bytes offered on a valid/ready port are split into two nibble writes, high nibble first. Both nibbles carry the register-select value given with the byte. Before `init_done`, and while a byte is still being sent, the port shows not-ready and takes no requests.

States, controller (`lcdi_init_rom_seq`): S_POWERUP (settling count) goes to S_ISSUE when the count ends. S_ISSUE (start one table write) always goes to S_WAIT. S_WAIT (wait for that write to finish) goes back to S_ISSUE with the next index, or to S_READY after the last index. S_READY (initialization finished) is held until reset.

States, nibble writer (`lcdi_nibble_writer`): W_IDLE goes to W_SETUP on start. W_SETUP (E low, data driven) goes to W_PULSE, and W_PULSE (E high) goes to W_RECOVER. W_RECOVER (E low, data held) goes back to W_IDLE. Each of the last three moves happens when that phase's cycle count runs out.

States, byte splitter (`lcdi_byte_splitter`): U_IDLE goes to U_HI when a byte is accepted. U_HI (start high nibble) goes to U_HI_WAIT, which goes to U_LO when the write is done. U_LO (start low nibble) goes to U_LO_WAIT, which returns to U_IDLE when the write is done.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `lcd_e`, `init_done` and `usr_ready` are all low.
- R2: No enable pulse occurs during the first POWERUP_CYCLES cycles after reset release.
- R3: During initialization, entry i of the table is the nibble INIT_TABLE[4*i+3:4*i]. Entries are sent in increasing index order, one enable pulse each, with `lcd_rs` = 0. The value `{lcd_rs, lcd_data}` seen when `lcd_e` falls equals `{0, entry}`.
- R4: Every nibble write holds E low with data driven for SETUP_CYCLES cycles. It then holds E high for PULSE_CYCLES cycles and E low for RECOVER_CYCLES cycles. During initialization, successive entries start every 1+SETUP_CYCLES+PULSE_CYCLES+RECOVER_CYCLES cycles, and entry 0 starts at cycle POWERUP_CYCLES after reset.
- R5: `init_done` rises exactly POWERUP_CYCLES + INIT_LEN*(1+SETUP_CYCLES+PULSE_CYCLES+RECOVER_CYCLES) cycles after reset release. It then stays high until reset, and reset clears it.
- R6: While `init_done` is low, `usr_ready` is low and `usr_valid` has no effect: no enable pulse is produced beyond the table entries.
- R7: After initialization, a byte offered with `usr_valid` high while `usr_ready` is high is sent as two nibble writes. The first carries bits 7:4 and the second bits 3:0. Both carry `lcd_rs` = `usr_rs`.
- R8: Once a byte is accepted, `usr_ready` stays low, and requests are ignored, for 2*(1+SETUP_CYCLES+PULSE_CYCLES+RECOVER_CYCLES) cycles. It is high again on the cycle after that.
- R9: Sequencing stops at the last entry. Exactly INIT_LEN enable pulses occur before `init_done` rises, and no entry is sent twice.
- R10: `lcd_rs` and `lcd_data` do not change while `lcd_e` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_valid | input | 1 | User byte request |
| usr_rs | input | 1 | Register-select value for the user byte |
| usr_byte | input | 8 | User byte to send |
| usr_ready | output | 1 | High when a user byte can be accepted |
| init_done | output | 1 | Initialization sequence complete |
| lcd_e | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Display register select |
| lcd_data | output | 4 | Display data nibble |

## Verification
The initialization walk runs against a table with repeated values, a zero nibble and a high-bit nibble. A per-cycle model predicts the enable level, so an early start, a wrong pulse width, a stretched or shortened pitch, or a swapped entry order each shows as a mismatch in a known cycle. A request held high through most of the initialization separates a correctly gated user port from one that leaks writes into the sequence. After that, bytes with both register-select values and with all-ones and all-zero contents separate high-first from low-first ordering and correct from wrong select propagation. A second request, held while the first byte is still being sent, shows whether the busy window ignores traffic.

// File: rtl/lcdi_pkg.sv
package lcdi_pkg;

    typedef enum logic [1:0] {
        S_POWERUP,
        S_ISSUE,
        S_WAIT,
        S_READY
    } seq_state_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SETUP,
        W_PULSE,
        W_RECOVER
    } wr_state_t;

    typedef enum logic [2:0] {
        U_IDLE,
        U_HI,
        U_HI_WAIT,
        U_LO,
        U_LO_WAIT
    } spl_state_t;

    typedef struct packed {
        logic       rs;
        logic [3:0] nib;
    } nib_req_t;

endpackage

// File: rtl/lcdi_nibble_writer.sv
module lcdi_nibble_writer
    import lcdi_pkg::*;
#(
    parameter int SETUP_CYCLES   = 3,
    parameter int PULSE_CYCLES   = 12,
    parameter int RECOVER_CYCLES = 750000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  nib_req_t   req,
    output logic       idle,
    output logic       done,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic [3:0] lcd_data
);

    localparam int MAX_AB = (SETUP_CYCLES > PULSE_CYCLES) ? SETUP_CYCLES : PULSE_CYCLES;
    localparam int MAXC   = (MAX_AB > RECOVER_CYCLES) ? MAX_AB : RECOVER_CYCLES;
    localparam int CW     = $clog2(MAXC + 1);

    wr_state_t   state;
    logic [CW-1:0] cnt;
    nib_req_t    hold;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE;
            cnt   <= '0;
            hold  <= '{rs: 1'b0, nib: 4'h0};
        end else begin
            unique case (state)
                W_IDLE: begin
                    if (start) begin
                        hold  <= req;
                        cnt   <= CW'(SETUP_CYCLES - 1);
                        state <= W_SETUP;
                    end
                end
                W_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= CW'(PULSE_CYCLES - 1);
                        state <= W_PULSE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                W_PULSE: begin
                    if (cnt == '0) begin
                        cnt   <= CW'(RECOVER_CYCLES - 1);
                        state <= W_RECOVER;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                W_RECOVER: begin
                    if (cnt == '0) begin
                        state <= W_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        lcd_e    = (state == W_PULSE);
        lcd_rs   = hold.rs;
        lcd_data = hold.nib;
        idle     = (state == W_IDLE);
        done     = (state == W_RECOVER) && (cnt == '0);
    end

    AST_E_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_data) && $stable(lcd_rs))); // R10

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> idle); // R4

endmodule

// File: rtl/lcdi_init_rom_seq.sv
module lcdi_init_rom_seq
    import lcdi_pkg::*;
#(
    parameter int                  POWERUP_CYCLES = 750000,
    parameter int                  INIT_LEN       = 8,
    parameter logic [4*INIT_LEN-1:0] INIT_TABLE   = 32'hC0822333
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_done,
    output logic     start,
    output nib_req_t req,
    output logic     init_done
);

    localparam int IDX_W = (INIT_LEN > 1) ? $clog2(INIT_LEN) : 1;
    localparam int PW    = $clog2(POWERUP_CYCLES + 1);
    localparam int LAST  = INIT_LEN - 1;

    seq_state_t     state;
    logic [PW-1:0]  pcnt;
    logic [IDX_W-1:0] idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_POWERUP;
            pcnt  <= '0;
            idx   <= '0;
        end else begin
            unique case (state)
                S_POWERUP: begin
                    if (pcnt == PW'(POWERUP_CYCLES - 1)) begin
                        state <= S_ISSUE;
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (wr_done) begin
                        if (idx == IDX_W'(LAST)) begin
                            state <= S_READY;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= S_ISSUE;
                        end
                    end
                end
                S_READY: state <= S_READY;
                default: state <= S_POWERUP;
            endcase
        end
    end

    // outputs
    always_comb begin
        start     = (state == S_ISSUE);
        req.rs    = 1'b0;
        req.nib   = INIT_TABLE[4*idx +: 4];
        init_done = (state == S_READY);
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) <= LAST)); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R5

    AST_NO_ISSUE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !start); // R9

endmodule

// File: rtl/lcdi_byte_splitter.sv
module lcdi_byte_splitter
    import lcdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       usr_valid,
    input  logic       usr_rs,
    input  logic [7:0] usr_byte,
    input  logic       wr_done,
    output logic       usr_ready,
    output logic       start,
    output nib_req_t   req
);

    spl_state_t state;
    logic [7:0] byte_q;
    logic       rs_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= U_IDLE;
            byte_q <= '0;
            rs_q   <= 1'b0;
        end else begin
            unique case (state)
                U_IDLE: begin
                    if (enable && usr_valid) begin
                        byte_q <= usr_byte;
                        rs_q   <= usr_rs;
                        state  <= U_HI;
                    end
                end
                U_HI:      state <= U_HI_WAIT;
                U_HI_WAIT: if (wr_done) state <= U_LO;
                U_LO:      state <= U_LO_WAIT;
                U_LO_WAIT: if (wr_done) state <= U_IDLE;
                default:   state <= U_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        usr_ready = enable && (state == U_IDLE);
        start     = (state == U_HI) || (state == U_LO);
        req.rs    = rs_q;
        req.nib   = (state == U_LO) ? byte_q[3:0] : byte_q[7:4];
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != U_IDLE) |=> $stable(byte_q)); // R8

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
    import lcdi_pkg::*;
#(
    parameter int                    POWERUP_CYCLES = 750000,
    parameter int                    SETUP_CYCLES   = 3,
    parameter int                    PULSE_CYCLES   = 12,
    parameter int                    RECOVER_CYCLES = 750000,
    parameter int                    INIT_LEN       = 8,
    parameter logic [4*INIT_LEN-1:0] INIT_TABLE     = 32'hC0822333
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       usr_valid,
    input  logic       usr_rs,
    input  logic [7:0] usr_byte,
    output logic       usr_ready,
    output logic       init_done,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic [3:0] lcd_data
);

    logic     seq_start, spl_start, wr_start, wr_idle, wr_done;
    nib_req_t seq_req, spl_req, wr_req;

    lcdi_init_rom_seq #(
        .POWERUP_CYCLES (POWERUP_CYCLES),
        .INIT_LEN       (INIT_LEN),
        .INIT_TABLE     (INIT_TABLE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_done   (wr_done),
        .start     (seq_start),
        .req       (seq_req),
        .init_done (init_done)
    );

    lcdi_byte_splitter u_spl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (init_done),
        .usr_valid (usr_valid),
        .usr_rs    (usr_rs),
        .usr_byte  (usr_byte),
        .wr_done   (wr_done),
        .usr_ready (usr_ready),
        .start     (spl_start),
        .req       (spl_req)
    );

    always_comb begin
        wr_start = seq_start | spl_start;
        wr_req   = init_done ? spl_req : seq_req;
    end

    lcdi_nibble_writer #(
        .SETUP_CYCLES   (SETUP_CYCLES),
        .PULSE_CYCLES   (PULSE_CYCLES),
        .RECOVER_CYCLES (RECOVER_CYCLES)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .req      (wr_req),
        .idle     (wr_idle),
        .done     (wr_done),
        .lcd_e    (lcd_e),
        .lcd_rs   (lcd_rs),
        .lcd_data (lcd_data)
    );

    AST_NO_USER_WRITE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !spl_start); // R6

    AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_start && spl_start)); // R7

    AST_INIT_RS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && lcd_e) |-> !lcd_rs); // R3

endmodule

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;

    localparam int POW   = 40;
    localparam int SU    = 3;
    localparam int PWID  = 5;
    localparam int RC    = 20;
    localparam int N     = 6;
    localparam int L     = 1 + SU + PWID + RC;
    localparam int TDONE = POW + N * L;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usr_valid = 1'b0;
    logic       usr_rs = 1'b0;
    logic [7:0] usr_byte = 8'h00;
    logic       usr_ready, init_done, lcd_e, lcd_rs;
    logic [3:0] lcd_data;

    lcd_init_seq #(
        .POWERUP_CYCLES (POW),
        .SETUP_CYCLES   (SU),
        .PULSE_CYCLES   (PWID),
        .RECOVER_CYCLES (RC),
        .INIT_LEN       (N),
        .INIT_TABLE     (24'hC08233)
    ) dut (
        .clk(clk), .rst_n(rst_n), .usr_valid(usr_valid), .usr_rs(usr_rs),
        .usr_byte(usr_byte), .usr_ready(usr_ready), .init_done(init_done),
        .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_data(lcd_data)
    );

    always #10 clk = ~clk;

    logic [3:0] tbl [N] = '{4'h3, 4'h3, 4'h2, 4'h8, 4'h0, 4'hC};
    logic [4:0] exp_q [$];
    int n = 0;
    int tests = 0;
    int fails = 0;
    int falls = 0;
    bit prev_e = 1'b0;
    bit model_on = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    // per-cycle reference model and falling-edge capture
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_e = 1'b0;
        end else begin
            if (model_on) begin
                if (n < TDONE) begin
                    int k, off;
                    bit e_exp;
                    e_exp = 1'b0;
                    k = 0;
                    if (n >= POW) begin
                        k   = (n - POW) / L;
                        off = (n - POW) % L;
                        e_exp = (off >= SU + 1) && (off <= SU + PWID);
                    end
                    check(lcd_e == e_exp, (n < POW) ? "R2" : "R4", "lcd_e level", lcd_e, e_exp);
                    check(init_done == 1'b0, "R5", "init_done early", init_done, 0);
                    check(usr_ready == 1'b0, "R6", "usr_ready before done", usr_ready, 0);
                    if (e_exp && lcd_e) begin
                        check(lcd_data == tbl[k], "R3", "init nibble under E", lcd_data, tbl[k]);
                        check(lcd_rs == 1'b0, "R10", "rs under E", lcd_rs, 0);
                    end
                end else begin
                    check(init_done == 1'b1, "R5", "init_done after sequence", init_done, 1);
                end
            end
            if (prev_e && !lcd_e) begin
                logic [4:0] got, want;
                got = {lcd_rs, lcd_data};
                falls++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected write", got, 0);
                end else begin
                    want = exp_q.pop_front();
                    check(got == want, (falls <= N) ? "R3" : "R7", "write at E fall", got, want);
                end
            end
            prev_e = lcd_e;
        end
    end

    task automatic send_byte(input bit rs, input logic [7:0] b, input bit junk);
        int a;
        exp_q.push_back({rs, b[7:4]});
        exp_q.push_back({rs, b[3:0]});
        @(negedge clk);
        usr_valid = 1'b1;
        usr_rs    = rs;
        usr_byte  = b;
        while (!usr_ready) @(negedge clk);
        a = n;
        @(negedge clk);
        usr_valid = 1'b0;
        if (junk) begin
            usr_valid = 1'b1;
            usr_rs    = ~rs;
            usr_byte  = ~b;
            repeat (L) @(negedge clk);
            usr_valid = 1'b0;
        end
        while (n < a + 2 * L) @(negedge clk);
        check(usr_ready == 1'b0, "R8", "ready during busy window", usr_ready, 0);
        @(negedge clk);
        check(usr_ready == 1'b1, "R8", "ready after two writes", usr_ready, 1);
    endtask

    initial begin
        repeat (400 * L) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", n, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) exp_q.push_back({1'b0, tbl[i]});
        repeat (3) @(negedge clk);
        check(lcd_e == 1'b0, "R1", "lcd_e in reset", lcd_e, 0);
        check(init_done == 1'b0, "R1", "init_done in reset", init_done, 0);
        check(usr_ready == 1'b0, "R1", "usr_ready in reset", usr_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(lcd_e == 1'b0 && init_done == 1'b0 && usr_ready == 1'b0, "R1",
              "outputs after release", {lcd_e, init_done, usr_ready}, 0);

        // request held during initialization must leak nothing
        while (n < 20) @(negedge clk);
        usr_valid = 1'b1;
        usr_rs    = 1'b1;
        usr_byte  = 8'hA5;
        while (n < TDONE - 3) @(negedge clk);
        usr_valid = 1'b0;
        while (n < TDONE + 2) @(negedge clk);
        check(falls == N, "R9", "pulse count during init", falls, N);
        check(exp_q.size() == 0, "R6", "pending after init", exp_q.size(), 0);

        send_byte(1'b1, 8'h86, 1'b1);
        send_byte(1'b0, 8'hC2, 1'b0);
        send_byte(1'b1, 8'hFF, 1'b0);
        send_byte(1'b0, 8'h00, 1'b0);
        repeat (2 * L) @(negedge clk);
        check(exp_q.size() == 0, "R7", "user writes outstanding", exp_q.size(), 0);
        check(falls == N + 8, "R7", "total pulse count", falls, N + 8);

        model_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(init_done == 1'b0, "R5", "init_done cleared by reset", init_done, 0);
        check(lcd_e == 1'b0 && usr_ready == 1'b0, "R1", "outputs in second reset",
              {lcd_e, usr_ready}, 0);
        finish_run();
    end

endmodule